// File: doc/BRIEF.md
# Auto-Incrementing Memory and Register Access Window

This block gives a host a narrow register interface onto two device-internal spaces: a word-wide synchronous SRAM and a bank of peripheral registers. Each space is reached through a window made of four host registers. One loads a read pointer, one loads a write pointer, one pushes write data and one pops read data. After a pointer is loaded, each data access moves one 32-bit word and advances that pointer by four bytes. A host can therefore stream a block of words by writing a single address and then issuing back-to-back data accesses.

The read side prefetches. Loading the read pointer starts a fetch at once. Each pop of the read-data register returns the current word, steps the pointer and starts the fetch of the next word. Pops may follow each other on consecutive cycles. The peripheral window keeps a 16-bit register offset in the low half of its pointers and a transfer-size code in a small field above it. The size code decides which byte lanes a peripheral access enables.

Top module: `memwin_bridge`

## Requirements
- R1: After reset, both memory pointers and both peripheral pointers read back as zero.
- R2: Writing the memory read-pointer register (select 0) fetches from that address at once. The next read of the memory read-data register (select 3) returns the word stored there, even when that read comes on the very next cycle.
- R3: Each read of select 3 returns the current word, advances the read pointer by 4 and fetches the following word. Consecutive-cycle reads return consecutive words.
- R4: After the memory write pointer (select 1) is loaded, each write to select 2 stores the host word at the pointer and advances the pointer by 4.
- R5: The read and write pointers step and load independently. Reading select 0 or 1 returns that pointer's current value.
- R6: Memory pointers wrap modulo 2^32, so 0xFFFFFFFC steps to 0x00000000 with no error.
- R7: Peripheral pointers (read select 4, write select 5) drive bits [15:0] onto the peripheral address. A step adds 4 to those 16 bits only and wraps within them. Bits [31:16] read back exactly as loaded.
- R8: Pointer bits [25:24] hold the byte count minus one. The peripheral byte enables are 0001, 0011, 0111 and 1111 for codes 0 to 3. On a write through select 6, only the enabled lanes change. Select 7 pops peripheral read data like select 3.
- R9: Writes to a read-data select (3 or 7) start no port access and change no pointer. Reads of a write-data select (2 or 6) return zero and change nothing.
- R10: With no host read or write, neither the SRAM port nor the peripheral port is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_wr | input | 1 | Host register write strobe |
| h_rd | input | 1 | Host register read strobe |
| h_sel | input | 3 | Host register select (0..7) |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for the selected register |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write when high, read when low |
| mem_addr | output | 32 | SRAM byte address |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data, one cycle after the access |
| prph_en | output | 1 | Peripheral access enable |
| prph_we | output | 1 | Peripheral write when high |
| prph_addr | output | 16 | Peripheral register offset |
| prph_be | output | 4 | Peripheral byte-lane enables |
| prph_wdata | output | 32 | Peripheral write data |
| prph_rdata | input | 32 | Peripheral read data, one cycle after the access |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 16-bit peripheral offset and the size code at bits [25:24]. Its SRAM and peripheral models decode only address bits [7:2]. The top word of both address spaces therefore aliases model word 63, which makes the 2^32 and 2^16 wrap points reachable with small models. With four byte lanes, all four size codes can be exercised, each merging a partial write into a known word.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
  // Host register selects. The window layout is read ptr, write ptr,
  // write data, read data; the peripheral window repeats it at +4.
  typedef enum logic [2:0] {
    SEL_MRPTR = 3'd0,
    SEL_MWPTR = 3'd1,
    SEL_MWDAT = 3'd2,
    SEL_MRDAT = 3'd3,
    SEL_PRPTR = 3'd4,
    SEL_PWPTR = 3'd5,
    SEL_PWDAT = 3'd6,
    SEL_PRDAT = 3'd7
  } win_sel_e;
endpackage

// File: rtl/memwin_lanes.sv
module memwin_lanes #(
  parameter int BYTES = 4,
  parameter int SZ_W  = 2
) (
  input  logic [SZ_W-1:0]  sz,
  output logic [BYTES-1:0] be
);
  // A lane is enabled when its index does not exceed the count-minus-one code.
  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign be[i] = (sz >= SZ_W'(i));
  end
endmodule

// File: rtl/memwin_port.sv
module memwin_port #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_rptr,
  input  logic              ld_wptr,
  input  logic              put,
  input  logic              take,
  input  logic [DATA_W-1:0] hwdata,
  output logic [DATA_W-1:0] rptr,
  output logic [DATA_W-1:0] wptr,
  output logic [DATA_W-1:0] rword,
  output logic              port_en,
  output logic              port_we,
  output logic [OFS_W-1:0]  port_addr,
  output logic [DATA_W-1:0] port_wdata,
  input  logic [DATA_W-1:0] port_rdata
);
  logic [DATA_W-1:0] rptr_q, rptr_d, wptr_q, wptr_d;
  logic [DATA_W-1:0] rbump, wbump;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              pend_q, pend_d;
  logic              fetch, rptr_en, wptr_en;

  // Pointer step: full-width add, or an add confined to the offset field.
  if (OFS_W >= DATA_W) begin : g_full
    assign rbump = rptr_q + DATA_W'(STEP);
    assign wbump = wptr_q + DATA_W'(STEP);
  end else begin : g_field
    assign rbump = {rptr_q[DATA_W-1:OFS_W], rptr_q[OFS_W-1:0] + OFS_W'(STEP)};
    assign wbump = {wptr_q[DATA_W-1:OFS_W], wptr_q[OFS_W-1:0] + OFS_W'(STEP)};
  end

  always_comb begin
    rptr_en = ld_rptr | take;
    wptr_en = ld_wptr | put;
    rptr_d  = ld_rptr ? hwdata : rbump;
    wptr_d  = ld_wptr ? hwdata : wbump;
    fetch   = ld_rptr | take;
    pend_d  = fetch;
    hold_d  = port_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (rptr_en) rptr_q <= rptr_d;
      if (wptr_en) wptr_q <= wptr_d;
      if (pend_q)  hold_q <= hold_d;
      pend_q <= pend_d;
    end
  end

  // A fetch issued last cycle is served straight from the port.
  assign rword      = pend_q ? port_rdata : hold_q;
  assign rptr       = rptr_q;
  assign wptr       = wptr_q;
  assign port_en    = fetch | put;
  assign port_we    = put;
  assign port_addr  = put ? wptr_q[OFS_W-1:0]
                          : (ld_rptr ? hwdata[OFS_W-1:0] : rbump[OFS_W-1:0]);
  assign port_wdata = hwdata;
endmodule

// File: rtl/memwin_bridge.sv
module memwin_bridge
  import memwin_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int POFS_W = 16,
  parameter int SZ_LSB = 24,
  parameter int STEP   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                h_wr,
  input  logic                h_rd,
  input  logic [2:0]          h_sel,
  input  logic [DATA_W-1:0]   h_wdata,
  output logic [DATA_W-1:0]   h_rdata,
  output logic                mem_en,
  output logic                mem_we,
  output logic [DATA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                prph_en,
  output logic                prph_we,
  output logic [POFS_W-1:0]   prph_addr,
  output logic [DATA_W/8-1:0] prph_be,
  output logic [DATA_W-1:0]   prph_wdata,
  input  logic [DATA_W-1:0]   prph_rdata
);
  localparam int BYTES = DATA_W / 8;
  localparam int SZ_W  = $clog2(BYTES);

  logic m_ld_r, m_ld_w, m_put, m_take;
  logic p_ld_r, p_ld_w, p_put, p_take;
  logic [DATA_W-1:0] m_rptr, m_wptr, m_rword;
  logic [DATA_W-1:0] p_rptr, p_wptr, p_rword;
  logic [SZ_W-1:0]   p_sz;
  win_sel_e          sel;

  assign sel = win_sel_e'(h_sel);

  // Host decode; a read strobe alongside a write is treated as a write.
  always_comb begin
    m_ld_r = h_wr && (sel == SEL_MRPTR);
    m_ld_w = h_wr && (sel == SEL_MWPTR);
    m_put  = h_wr && (sel == SEL_MWDAT);
    m_take = h_rd && !h_wr && (sel == SEL_MRDAT);
    p_ld_r = h_wr && (sel == SEL_PRPTR);
    p_ld_w = h_wr && (sel == SEL_PWPTR);
    p_put  = h_wr && (sel == SEL_PWDAT);
    p_take = h_rd && !h_wr && (sel == SEL_PRDAT);
  end

  memwin_port #(.DATA_W(DATA_W), .OFS_W(DATA_W), .STEP(STEP)) u_mem_win (
    .clk(clk), .rst_n(rst_n),
    .ld_rptr(m_ld_r), .ld_wptr(m_ld_w), .put(m_put), .take(m_take),
    .hwdata(h_wdata), .rptr(m_rptr), .wptr(m_wptr), .rword(m_rword),
    .port_en(mem_en), .port_we(mem_we), .port_addr(mem_addr),
    .port_wdata(mem_wdata), .port_rdata(mem_rdata)
  );

  memwin_port #(.DATA_W(DATA_W), .OFS_W(POFS_W), .STEP(STEP)) u_prph_win (
    .clk(clk), .rst_n(rst_n),
    .ld_rptr(p_ld_r), .ld_wptr(p_ld_w), .put(p_put), .take(p_take),
    .hwdata(h_wdata), .rptr(p_rptr), .wptr(p_wptr), .rword(p_rword),
    .port_en(prph_en), .port_we(prph_we), .port_addr(prph_addr),
    .port_wdata(prph_wdata), .port_rdata(prph_rdata)
  );

  // Size code follows the pointer that drives the current access.
  always_comb begin
    if (p_put)       p_sz = p_wptr[SZ_LSB +: SZ_W];
    else if (p_ld_r) p_sz = h_wdata[SZ_LSB +: SZ_W];
    else             p_sz = p_rptr[SZ_LSB +: SZ_W];
  end

  memwin_lanes #(.BYTES(BYTES), .SZ_W(SZ_W)) u_lanes (
    .sz(p_sz), .be(prph_be)
  );

  always_comb begin
    case (sel)
      SEL_MRPTR: h_rdata = m_rptr;
      SEL_MWPTR: h_rdata = m_wptr;
      SEL_MRDAT: h_rdata = m_rword;
      SEL_PRPTR: h_rdata = p_rptr;
      SEL_PWPTR: h_rdata = p_wptr;
      SEL_PRDAT: h_rdata = p_rword;
      default:   h_rdata = '0;
    endcase
  end
endmodule

// File: rtl/memwin_bridge_chk.sv
module memwin_bridge_chk
  import memwin_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        h_wr,
  input logic        h_rd,
  input logic [2:0]  h_sel,
  input logic [31:0] h_wdata,
  input logic [31:0] h_rdata,
  input logic        mem_en,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] mem_rdata,
  input logic        prph_en,
  input logic        prph_we,
  input logic [15:0] prph_addr,
  input logic [3:0]  prph_be,
  input logic [31:0] prph_wdata,
  input logic [31:0] prph_rdata
);
  logic [31:0] last_fetch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_fetch <= '0;
    else if (mem_en && !mem_we) last_fetch <= mem_addr;
  end

  AST_LOAD_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_sel == SEL_MRPTR) |-> (mem_en && !mem_we && mem_addr == h_wdata)); // R2

  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && !h_wr && h_sel == SEL_MRDAT) |-> (mem_en && !mem_we && mem_addr == last_fetch + 32'd4)); // R3

  AST_RDATA_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_en && !mem_we) && h_rd && !h_wr && h_sel == SEL_MRDAT) |-> (h_rdata == mem_rdata)); // R2

  AST_WRITE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_sel == SEL_MWDAT) |-> (mem_en && mem_we && mem_wdata == h_wdata)); // R4

  AST_LANES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    prph_en |-> ($onehot({1'b0, prph_be} + 5'd1) && prph_be[0])); // R8

  AST_RDSEL_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && (h_sel == SEL_MRDAT || h_sel == SEL_PRDAT)) |-> (!mem_en && !prph_en)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_wr && !h_rd) |-> (!mem_en && !prph_en)); // R10

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_en && prph_en)); // R10

  logic unused_ok;
  assign unused_ok = ^{prph_addr, prph_we, prph_wdata, prph_rdata};
endmodule

bind memwin_bridge memwin_bridge_chk u_chk (.*);

// File: tb/memwin_bridge_bench.sv
`timescale 1ns/1ps
module memwin_bridge_bench;
  logic        clk, rst_n;
  logic        h_wr, h_rd;
  logic [2:0]  h_sel;
  logic [31:0] h_wdata, h_rdata;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        prph_en, prph_we;
  logic [15:0] prph_addr;
  logic [3:0]  prph_be;
  logic [31:0] prph_wdata, prph_rdata;

  int checks = 0;
  int errors = 0;
  logic        cap_men, cap_pen;
  logic [3:0]  cap_be;
  logic [31:0] rv;

  memwin_bridge u_memwin_bridge (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Memory and peripheral models: one-cycle read latency, index by addr[7:2].
  logic [31:0] smem [64];
  logic [31:0] pmem [64];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) smem[mem_addr[7:2]] <= mem_wdata;
      else        mem_rdata <= smem[mem_addr[7:2]];
    end
    if (prph_en) begin
      if (prph_we) begin
        for (int b = 0; b < 4; b++)
          if (prph_be[b]) pmem[prph_addr[7:2]][8*b +: 8] <= prph_wdata[8*b +: 8];
      end else prph_rdata <= pmem[prph_addr[7:2]];
    end
  end

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [2:0] s, input logic [31:0] v);
    @(negedge clk);
    h_wr = 1'b1; h_rd = 1'b0; h_sel = s; h_wdata = v;
    #1;
    cap_men = mem_en; cap_pen = prph_en; cap_be = prph_be;
  endtask

  task automatic hr(input logic [2:0] s, output logic [31:0] v);
    @(negedge clk);
    h_wr = 1'b0; h_rd = 1'b1; h_sel = s; h_wdata = '0;
    #1;
    v = h_rdata;
  endtask

  task automatic idle();
    @(negedge clk);
    h_wr = 1'b0; h_rd = 1'b0; h_sel = '0; h_wdata = '0;
    #1;
  endtask

  // {req, read, sel, value}: read=0 writes value, read=1 expects value.
  localparam int NV = 14;
  localparam logic [39:0] VEC [NV] = '{
    {4'd4, 1'b0, 3'd1, 32'h0000_0020},
    {4'd4, 1'b0, 3'd2, 32'h1111_1111},
    {4'd4, 1'b0, 3'd2, 32'h2222_2222},
    {4'd4, 1'b0, 3'd2, 32'h3333_3333},
    {4'd4, 1'b1, 3'd1, 32'h0000_002C},
    {4'd2, 1'b0, 3'd0, 32'h0000_0020},
    {4'd2, 1'b1, 3'd3, 32'h1111_1111},
    {4'd3, 1'b1, 3'd3, 32'h2222_2222},
    {4'd3, 1'b1, 3'd3, 32'h3333_3333},
    {4'd3, 1'b1, 3'd0, 32'h0000_002C},
    {4'd5, 1'b1, 3'd1, 32'h0000_002C},
    {4'd5, 1'b0, 3'd0, 32'h0000_0024},
    {4'd5, 1'b1, 3'd1, 32'h0000_002C},
    {4'd5, 1'b1, 3'd3, 32'h2222_2222}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; h_wr = 1'b0; h_rd = 1'b0; h_sel = '0; h_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: pointers clear after reset
    hr(3'd0, rv); check(1, rv, 32'h0);
    hr(3'd1, rv); check(1, rv, 32'h0);
    hr(3'd4, rv); check(1, rv, 32'h0);
    hr(3'd5, rv); check(1, rv, 32'h0);
    // R10: no port activity while idle
    idle(); check(10, {31'b0, mem_en | prph_en}, 32'h0);

    // R2 R3 R4 R5: table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][35]) begin
        hr(VEC[i][34:32], rv);
        check(int'(VEC[i][39:36]), rv, VEC[i][31:0]);
      end else hw(VEC[i][34:32], VEC[i][31:0]);
    end
    idle();

    // R9: writes to read-data selects and reads of write-data selects do nothing
    hw(3'd3, 32'hDEAD_BEEF); check(9, {31'b0, cap_men | cap_pen}, 32'h0);
    hw(3'd7, 32'hDEAD_BEEF); check(9, {31'b0, cap_men | cap_pen}, 32'h0);
    hr(3'd0, rv); check(9, rv, 32'h0000_0028);
    hr(3'd2, rv); check(9, rv, 32'h0);
    hr(3'd6, rv); check(9, rv, 32'h0);
    hr(3'd1, rv); check(9, rv, 32'h0000_002C);

    // R6: wrap at the top of the 32-bit space
    hw(3'd1, 32'hFFFF_FFFC); hw(3'd2, 32'hCAFE_F00D);
    hr(3'd1, rv); check(6, rv, 32'h0);
    hw(3'd0, 32'hFFFF_FFFC);
    hr(3'd3, rv); check(6, rv, 32'hCAFE_F00D);
    hr(3'd0, rv); check(6, rv, 32'h0);

    // R7: peripheral offset wraps inside 16 bits, upper bits kept
    hw(3'd5, 32'hF300_FFFC); hw(3'd6, 32'h5A5A_1234);
    check(8, {28'b0, cap_be}, 32'hF);
    hr(3'd5, rv); check(7, rv, 32'hF300_0000);
    hw(3'd4, 32'hF300_FFFC);
    hr(3'd7, rv); check(7, rv, 32'h5A5A_1234);
    hr(3'd4, rv); check(7, rv, 32'hF300_0000);

    // R8: size code selects the low byte lanes
    hw(3'd5, 32'h0300_0040); hw(3'd6, 32'hAABB_CCDD);
    hw(3'd5, 32'h0000_0040); hw(3'd6, 32'h1122_3344);
    check(8, {28'b0, cap_be}, 32'h1);
    hw(3'd5, 32'h0100_0040); hw(3'd6, 32'h5566_7788);
    check(8, {28'b0, cap_be}, 32'h3);
    hw(3'd5, 32'h0200_0040); hw(3'd6, 32'h9988_7766);
    check(8, {28'b0, cap_be}, 32'h7);
    hw(3'd4, 32'h0300_0040);
    hr(3'd7, rv); check(8, rv, 32'hAA88_7766);
    idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule